// File: doc/BRIEF.md
# SPI Receive Path with Selectable Buffering

This block is the receive half of an SPI host. It takes a serial data line and the SPI clock, both asynchronous to the system clock. It samples each bit on the rising SPI clock edge, most significant bit first, and assembles 8-bit bytes. Received bytes go into a single storage array. A mode bit sets how much of that array is used. In single-unit mode only one byte can be held, and it behaves like a plain data register. In sequential mode the array is a 32-entry FIFO.

Software drives the block through a one-cycle write strobe that carries these fields:
- the reception mode
- a receive enable
- a FIFO fill threshold select
- a transmit enable for the companion transmitter
- a write-1 overrun clear

Received bytes are read from a read port with a read strobe. Status outputs report the following:
- the current settings
- the fill count
- a sticky overrun flag
- a transmit-end flag
- a level-sensitive receive-full interrupt

The block has two write guards. A mode change is refused while a byte is partly shifted in. All control writes are refused while a transmission is running and has not yet reported its end.

Top module: `spi_rx_buffered`

## Requirements
- R1: After a synchronous active-low reset the following hold: single-unit mode selected, receive disabled, threshold select 0, transmit enable 0, fill count 0, overrun 0, transmit-end 0 and interrupt 0.
- R2: While receive is enabled, each rising edge of `sck` shifts in `sdi` and eight edges form one byte, MSB first. While receive is disabled, edges are not counted and no byte is stored.
- R3: In single-unit mode (`cfg_seq`=0) at most one byte is held. The interrupt is high while that byte is held, and reading it with `rd_en` returns the byte and empties the store.
- R4: In sequential mode (`cfg_seq`=1) up to 32 bytes are held and read back in arrival order. Each `rd_en` pulse removes one byte and lowers `rx_count` by one.
- R5: In sequential mode the interrupt is high exactly while `rx_count` is at least the threshold. The threshold is 16 when `cfg_thr32`=0 and 32 when `cfg_thr32`=1.
- R6: A byte that completes while the store is at capacity is discarded and sets `rx_ovr`. The flag stays set until a write with `cfg_ovr_clr`=1 is accepted.
- R7: A write that would change the mode while a byte is partly received leaves the mode unchanged. An accepted mode change empties the store.
- R8: While `tx_en` is 1 and `tx_end` is 0, every control write is ignored.
- R9: `tx_end` is set by a `tx_done` pulse while `tx_en` is 1. It is cleared by an accepted write that raises `tx_en` from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | SPI clock, asynchronous |
| sdi | input | 1 | Serial receive data, asynchronous |
| cfg_we | input | 1 | Control write strobe |
| cfg_seq | input | 1 | Mode: 0 single-unit, 1 sequential |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_thr32 | input | 1 | Threshold select: 0 gives 16, 1 gives 32 |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_ovr_clr | input | 1 | Write 1 to clear overrun |
| tx_done | input | 1 | Transfer-complete pulse from the transmitter |
| rd_en | input | 1 | Read strobe, removes the oldest byte |
| rd_data | output | 8 | Oldest held byte |
| rx_count | output | 6 | Number of bytes held |
| stat_seq | output | 1 | Current mode |
| stat_rx_en | output | 1 | Current receive enable |
| stat_thr32 | output | 1 | Current threshold select |
| stat_tx_en | output | 1 | Current transmit enable |
| rx_ovr | output | 1 | Sticky overrun flag |
| tx_end | output | 1 | Transmit-end flag |
| rx_irq | output | 1 | Receive-full interrupt, level |

## Verification
The hardest situation to reach is a mode write that lands while a byte is only partly shifted in. The bench stops the serial stream after three bits and then issues the mode write, so the bit counter is nonzero. It then sends the remaining five bits and confirms that the completed byte was still held with single-unit capacity. Threshold edges are reached by filling the FIFO one byte at a time to one below and then exactly at 16 and 32. The interrupt is checked at each step, the drop is checked at 33, and a scoreboard queue confirms arrival order on readback.

// File: rtl/spi_rx_pkg.sv
// Shared types for the SPI receive path.
package spi_rx_pkg;
    // Reception mode encoding; the value is the cfg_seq bit.
    typedef enum logic {
        RXM_UNIT = 1'b0,
        RXM_SEQ  = 1'b1
    } rx_mode_e;

    // One control write, as presented on the register-style interface.
    typedef struct packed {
        logic seq;
        logic rx_en;
        logic thr32;
        logic tx_en;
        logic ovr_clr;
    } rx_cfg_t;
endpackage

// File: rtl/spi_rx_sampler.sv
// Bit sampler and byte assembler.
// Synchronises sck and sdi into clk, detects rising sck edges and shifts
// bits in MSB first. Emits a one-cycle byte_valid with the byte after the
// last bit. Assumes sck half-periods are longer than SYNC+1 clk cycles.
module spi_rx_sampler #(
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          sck,
    input  logic          sdi,
    output logic          byte_valid,
    output logic [DW-1:0] byte_data,
    output logic          busy
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;

    logic [SYNC-1:0] sck_pipe;
    logic [SYNC-1:0] sdi_pipe;
    logic            sck_last;
    logic [CW-1:0]   bit_cnt;
    logic [DW-1:0]   shreg;
    logic            rise;
    logic [DW-1:0]   shreg_next;

    assign rise       = sck_pipe[SYNC-1] & ~sck_last;
    assign shreg_next = {shreg[DW-2:0], sdi_pipe[SYNC-1]};
    assign busy       = (bit_cnt != '0);

    // Purpose: bring sck and sdi into the clk domain and remember last sck.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            sdi_pipe <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_pipe <= {sck_pipe[SYNC-2:0], sck};
            sdi_pipe <= {sdi_pipe[SYNC-2:0], sdi};
            sck_last <= sck_pipe[SYNC-1];
        end
    end

    // Purpose: shift bits on rising sck and flag each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (!enable) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg <= shreg_next;
                if (bit_cnt == CW'(DW - 1)) begin
                    bit_cnt    <= '0;
                    byte_valid <= 1'b1;
                    byte_data  <= shreg_next;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R2: a byte needs fresh edges, so valid never lasts two cycles.
    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
    // R2: with receive disabled no byte completes.
    a_r2_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !byte_valid);
endmodule

// File: rtl/spi_rx_store.sv
// Receive storage: one array of DEPTH bytes used as a FIFO.
// In single-unit mode its capacity is limited to one entry, so it acts as
// a data register. A push at capacity is discarded and reported on
// `dropped`. Flush empties it. Assumes push and pop come from clk logic.
module spi_rx_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       seq_mode,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DW-1:0]              push_data,
    input  logic                       pop,
    output logic [DW-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       dropped
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [DW-1:0]   mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CNTW-1:0] cap;
    logic            at_cap;
    logic            accept;
    logic            take;

    assign cap     = seq_mode ? CNTW'(DEPTH) : CNTW'(1);
    assign at_cap  = (count >= cap);
    assign accept  = push && !at_cap && !flush;
    assign take    = pop && (count != '0) && !flush;
    assign dropped = push && at_cap && !flush;
    assign head    = mem[rd_ptr];

    // Purpose: write an accepted byte into the array.
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Purpose: advance pointers and the fill count, or empty on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (take) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3/R4: the fill count never passes the capacity of the current mode.
    a_r4_count_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
        count <= cap);
    // R6: a discarded byte leaves the count as it was, or lowers it on a read.
    a_r6_drop_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> count <= $past(count));
    // R7: a flush leaves the store empty.
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);
endmodule

// File: rtl/spi_rx_ctrl.sv
// Control register, guards, flags and interrupt.
// Holds mode, enables and threshold. Refuses every write while a transfer
// is running without an end report, and refuses mode changes while a byte
// is partly received. An accepted mode change requests a store flush.
// Also keeps the sticky overrun flag, the transmit-end flag and the level
// interrupt.
module spi_rx_ctrl
    import spi_rx_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int LOW_THR = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  rx_cfg_t                    cfg_in,
    input  logic                       rx_busy,
    input  logic                       dropped,
    input  logic                       tx_done,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    output rx_mode_e                   mode,
    output logic                       rx_en,
    output logic                       thr32,
    output logic                       tx_en,
    output logic                       tx_end,
    output logic                       ovr,
    output logic                       irq,
    output logic                       flush
);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic            locked;
    logic            wr_ok;
    logic            mode_chg;
    logic [CNTW-1:0] level;

    assign locked   = tx_en && !tx_end;
    assign wr_ok    = cfg_we && !locked;
    assign mode_chg = wr_ok && !rx_busy && (rx_mode_e'(cfg_in.seq) != mode);
    assign flush    = mode_chg;

    // Purpose: pick the fill level that raises the interrupt.
    always_comb begin
        if (mode == RXM_SEQ) begin
            level = thr32 ? CNTW'(DEPTH) : CNTW'(LOW_THR);
        end else begin
            level = CNTW'(1);
        end
    end

    assign irq = (count >= level);

    // Purpose: update control fields on accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= RXM_UNIT;
            rx_en <= 1'b0;
            thr32 <= 1'b0;
            tx_en <= 1'b0;
        end else if (wr_ok) begin
            if (mode_chg) begin
                mode <= rx_mode_e'(cfg_in.seq);
            end
            rx_en <= cfg_in.rx_en;
            thr32 <= cfg_in.thr32;
            tx_en <= cfg_in.tx_en;
        end
    end

    // Purpose: set transmit-end on completion, clear it on a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_end <= 1'b0;
        end else if (wr_ok && cfg_in.tx_en && !tx_en) begin
            tx_end <= 1'b0;
        end else if (tx_done && tx_en) begin
            tx_end <= 1'b1;
        end
    end

    // Purpose: sticky overrun, set by a drop, cleared by an accepted write-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
        end else if (dropped) begin
            ovr <= 1'b1;
        end else if (wr_ok && cfg_in.ovr_clr) begin
            ovr <= 1'b0;
        end
    end

    // R7: the mode holds while a byte is partly received.
    a_r7_mode_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |=> mode == $past(mode));
    // R8: a locked write changes no control field.
    a_r8_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (thr32 == $past(thr32)) && (rx_en == $past(rx_en))
                   && (mode == $past(mode)) && tx_en);
    // R9: transmit-end rises only after a completion pulse.
    a_r9_end_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_end) |-> $past(tx_done));
    // R6: overrun is never cleared by a drop-free cycle without a write.
    a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr && !cfg_we |=> ovr);
endmodule

// File: rtl/spi_rx_buffered.sv
// Top of the SPI receive path: sampler, storage and control.
// Assumes sck and sdi are asynchronous and sck is slow compared to clk.
module spi_rx_buffered #(
    parameter int DW      = 8,
    parameter int DEPTH   = 32,
    parameter int LOW_THR = 16,
    parameter int SYNC    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sck,
    input  logic                       sdi,
    input  logic                       cfg_we,
    input  logic                       cfg_seq,
    input  logic                       cfg_rx_en,
    input  logic                       cfg_thr32,
    input  logic                       cfg_tx_en,
    input  logic                       cfg_ovr_clr,
    input  logic                       tx_done,
    input  logic                       rd_en,
    output logic [DW-1:0]              rd_data,
    output logic [$clog2(DEPTH+1)-1:0] rx_count,
    output logic                       stat_seq,
    output logic                       stat_rx_en,
    output logic                       stat_thr32,
    output logic                       stat_tx_en,
    output logic                       rx_ovr,
    output logic                       tx_end,
    output logic                       rx_irq
);
    import spi_rx_pkg::*;

    rx_cfg_t       cfg_bus;
    rx_mode_e      mode;
    logic          byte_valid;
    logic [DW-1:0] byte_data;
    logic          rx_busy;
    logic          dropped;
    logic          flush;

    assign cfg_bus  = '{seq: cfg_seq, rx_en: cfg_rx_en, thr32: cfg_thr32,
                        tx_en: cfg_tx_en, ovr_clr: cfg_ovr_clr};
    assign stat_seq = (mode == RXM_SEQ);

    spi_rx_sampler #(.DW(DW), .SYNC(SYNC)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (stat_rx_en),
        .sck        (sck),
        .sdi        (sdi),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .busy       (rx_busy)
    );

    spi_rx_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_mode  (stat_seq),
        .flush     (flush),
        .push      (byte_valid),
        .push_data (byte_data),
        .pop       (rd_en),
        .head      (rd_data),
        .count     (rx_count),
        .dropped   (dropped)
    );

    spi_rx_ctrl #(.DEPTH(DEPTH), .LOW_THR(LOW_THR)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_in  (cfg_bus),
        .rx_busy (rx_busy),
        .dropped (dropped),
        .tx_done (tx_done),
        .count   (rx_count),
        .mode    (mode),
        .rx_en   (stat_rx_en),
        .thr32   (stat_thr32),
        .tx_en   (stat_tx_en),
        .tx_end  (tx_end),
        .ovr     (rx_ovr),
        .irq     (rx_irq),
        .flush   (flush)
    );
endmodule

// File: tb/test_spi_rx_buffered.sv
module test_spi_rx_buffered;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, sdi = 1'b0;
    logic       cfg_we = 1'b0, cfg_seq = 1'b0, cfg_rx_en = 1'b0;
    logic       cfg_thr32 = 1'b0, cfg_tx_en = 1'b0, cfg_ovr_clr = 1'b0;
    logic       tx_done = 1'b0, rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [5:0] rx_count;
    logic       stat_seq, stat_rx_en, stat_thr32, stat_tx_en;
    logic       rx_ovr, tx_end, rx_irq;

    int checks = 0;
    int errors = 0;
    int cap_model = 1;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    spi_rx_buffered i_spi_rx_buffered (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi),
        .cfg_we(cfg_we), .cfg_seq(cfg_seq), .cfg_rx_en(cfg_rx_en),
        .cfg_thr32(cfg_thr32), .cfg_tx_en(cfg_tx_en), .cfg_ovr_clr(cfg_ovr_clr),
        .tx_done(tx_done), .rd_en(rd_en), .rd_data(rd_data), .rx_count(rx_count),
        .stat_seq(stat_seq), .stat_rx_en(stat_rx_en), .stat_thr32(stat_thr32),
        .stat_tx_en(stat_tx_en), .rx_ovr(rx_ovr), .tx_end(tx_end), .rx_irq(rx_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    // Driver: serial bits, MSB of val first, n bits.
    task automatic send_bits(input logic [7:0] val, input int n);
        for (int i = 0; i < n; i++) begin
            sdi = val[7 - i]; sck = 1'b0;
            repeat (3) tick();
            sck = 1'b1;
            repeat (3) tick();
        end
        sck = 1'b0;
        repeat (6) tick();
    endtask

    // Driver: a whole byte; the expected item joins the scoreboard if it fits.
    task automatic send_byte(input logic [7:0] val);
        send_bits(val, 8);
        if (exp_q.size() < cap_model) exp_q.push_back(val);
    endtask

    task automatic wr_cfg(input logic s, input logic e, input logic t,
                          input logic x, input logic c);
        tick();
        cfg_we = 1'b1; cfg_seq = s; cfg_rx_en = e; cfg_thr32 = t;
        cfg_tx_en = x; cfg_ovr_clr = c;
        tick();
        cfg_we = 1'b0; cfg_ovr_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read();
        tick();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compares the head against the scoreboard on every read.
    always @(negedge clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                check("R4 read with empty model", 1, 0);
            end else begin
                check("R3/R4 read data", int'(rd_data), int'(exp_q[0]));
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 mode", stat_seq, 0);
        check("R1 rx_en", stat_rx_en, 0);
        check("R1 count", rx_count, 0);
        check("R1 ovr", rx_ovr, 0);
        check("R1 tx_end", tx_end, 0);
        check("R1 irq", rx_irq, 0);

        // R3 single-unit reception
        wr_cfg(0, 1, 0, 0, 0);
        send_byte(8'hA5);
        check("R3 count after byte", rx_count, 1);
        check("R3 irq while held", rx_irq, 1);
        // R6 second byte dropped
        send_byte(8'h3C);
        check("R6 ovr set", rx_ovr, 1);
        check("R6 count unchanged", rx_count, 1);
        do_read();
        check("R3 count after read", rx_count, 0);
        check("R3 irq after read", rx_irq, 0);
        check("R6 ovr sticky", rx_ovr, 1);
        wr_cfg(0, 1, 0, 0, 1);
        check("R6 ovr cleared", rx_ovr, 0);

        // R2 receive disabled ignores traffic
        wr_cfg(0, 0, 0, 0, 0);
        send_bits(8'hFF, 8);
        check("R2 disabled count", rx_count, 0);
        wr_cfg(0, 1, 0, 0, 0);

        // R7 mode write mid-byte is refused; byte completes in unit mode
        send_bits(8'h96, 3);
        wr_cfg(1, 1, 0, 0, 0);
        check("R7 mode held busy", stat_seq, 0);
        send_bits(8'h96 << 3, 5);
        exp_q.push_back(8'h96);
        check("R2 byte via split bits count", rx_count, 1);
        do_read();

        // R7 accepted mode change flushes
        send_byte(8'h11);
        wr_cfg(1, 1, 0, 0, 0);
        exp_q.delete();
        cap_model = 32;
        check("R7 mode switched", stat_seq, 1);
        check("R7 flushed", rx_count, 0);

        // R5 threshold 16
        for (int i = 0; i < 15; i++) send_byte(8'(i * 7 + 1));
        check("R5 irq below 16", rx_irq, 0);
        send_byte(8'hEE);
        check("R5 irq at 16", rx_irq, 1);
        check("R4 count 16", rx_count, 16);
        do_read();
        check("R5 irq at 15", rx_irq, 0);
        for (int i = 0; i < 15; i++) do_read();
        check("R4 empty", rx_count, 0);

        // R5 threshold 32, R6 drop at 33
        wr_cfg(1, 1, 1, 0, 0);
        for (int i = 0; i < 31; i++) send_byte(8'(8'hC3 ^ i));
        check("R5 irq at 31 thr32", rx_irq, 0);
        send_byte(8'h5A);
        check("R5 irq at 32", rx_irq, 1);
        check("R6 no ovr yet", rx_ovr, 0);
        send_byte(8'h77);
        check("R6 ovr at 33", rx_ovr, 1);
        check("R4 count capped", rx_count, 32);
        for (int i = 0; i < 32; i++) do_read();
        check("R4 drained", rx_count, 0);

        // R8 lock while transfer runs, R9 end flag
        wr_cfg(1, 1, 1, 1, 0);
        check("R8 tx_en set", stat_tx_en, 1);
        wr_cfg(1, 1, 0, 1, 1);
        check("R8 thr held", stat_thr32, 1);
        check("R8 ovr clear ignored", rx_ovr, 1);
        tick(); tx_done = 1'b1; tick(); tx_done = 1'b0;
        @(negedge clk);
        check("R9 tx_end set", tx_end, 1);
        wr_cfg(1, 1, 0, 0, 1);
        check("R8 write after end", stat_thr32, 0);
        check("R8 ovr cleared after end", rx_ovr, 0);
        wr_cfg(1, 1, 0, 1, 0);
        check("R9 tx_end cleared on start", tx_end, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule